// File: doc/BRIEF.md
# Self-Test Pattern Generator and Signature Compressor

This block drives a built-in self-test of a combinational circuit. A 4-bit linear feedback shift register supplies a pseudorandom test word to the circuit under test on every cycle of a run. A 4-bit multiple-input signature register folds the circuit's four parallel response bits into a running signature on each of those cycles. When the programmed number of cycles has elapsed, the signature is compared with a known-good value. The result is a pass flag that stays valid until the next run is started.

Software or a test controller sets the generator's starting state with a seed load. It then starts a run with a cycle count and the expected signature, waits for `done`, and reads `pass`. The generator is not reloaded between runs, so a second run continues the pseudorandom sequence where the first one stopped. The circuit under test lies outside the block.

Top module: `bist_engine`

## Requirements
- R1: After reset, `pattern` is 4'b1000, `signature` is 0, and `busy`, `done` and `pass` are 0.
- R2: On each cycle with `busy` high, the generator shifts one place toward bit 0 and takes bit3 XOR bit0 into bit 3 (for example 1000 becomes 1100, then 1110, 1111, 0111, 1011). While `busy` is low and no seed is loaded, `pattern` does not change.
- R3: Starting from 1000, the generator passes through all 15 non-zero states and returns to 1000 after exactly 15 steps.
- R4: A seed load while idle sets `pattern` to `seed_in` on the next cycle. A seed of 0000 is replaced by 1000.
- R5: A start while idle clears the signature to 0 and captures `cycle_count` and `golden`.
- R6: On each cycle with `busy` high, the new signature is {s3^s0, s3, s2, s1} XOR `response`, where `response` bit i enters stage i.
- R7: A run with count N > 0 keeps `busy` high for exactly N cycles, and then raises `done`. A count of 0 raises `done` on the cycle after the start, with no compression. `busy` and `done` are never high together.
- R8: While `done` is high, `pass` is 1 exactly when the signature equals the captured `golden`. `done`, `pass` and `signature` hold until the next start.
- R9: `seed_load` and `start` have no effect while `busy` is high. The run length and the pattern stream continue unchanged.
- R10: `pattern` is never 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_in` into the generator (idle only) |
| seed_in | input | 4 | Generator seed |
| start | input | 1 | Begin a run (idle only) |
| cycle_count | input | 8 | Number of compression cycles for the run |
| golden | input | 4 | Known-good signature, captured at start |
| response | input | 4 | Parallel outputs of the circuit under test |
| pattern | output | 4 | Current test word to the circuit under test |
| signature | output | 4 | Accumulated signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; `pass` is valid |
| pass | output | 1 | Signature matched the golden value |

## Verification
The hardest condition to reach from the ports is a `seed_load` and `start` that arrive in the middle of a run. These must leave both the run length and the pattern stream untouched. The bench raises both in the third busy cycle of a dedicated run. It then keeps checking every pattern and the final cycle count against its own model. A failing signature is produced by a bench-side stand-in circuit that flips one response bit whenever a chosen pattern appears. The compressor is linear and invertible, so that single error must show up in the signature. Zero-seed substitution and the zero-length run are covered with directed starts. All 16 seed values are also swept across several run lengths.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } bist_phase_e;

    localparam int unsigned BIST_W_DFLT  = 4;
    localparam int unsigned BIST_CW_DFLT = 8;

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
    parameter int unsigned W        = 4,
    parameter logic [W-1:0] TAPS    = 4'b1001,
    parameter logic [W-1:0] RST_SEED = 4'b1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    output logic [W-1:0] state
);

    typedef struct packed {
        logic [W-1:0] st;
    } gen_t;

    gen_t gen_d, gen_q;
    logic fb;

    always_comb begin
        gen_d = gen_q;
        fb    = ^(gen_q.st & TAPS);
        if (load_en) begin
            // an all-zero word would lock the register: substitute the default seed
            gen_d.st = (load_val == '0) ? RST_SEED : load_val;
        end else if (step_en) begin
            gen_d.st = {fb, gen_q.st[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.st <= RST_SEED;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign state = gen_q.st;

endmodule

// File: rtl/bist_sig_comp.sv
module bist_sig_comp #(
    parameter int unsigned W     = 4,
    parameter logic [W-1:0] TAPS = 4'b1001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_en,
    input  logic         step_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);

    typedef struct packed {
        logic [W-1:0] acc;
    } comp_t;

    comp_t comp_d, comp_q;
    logic [W-1:0] shifted;

    always_comb begin
        comp_d  = comp_q;
        shifted = {^(comp_q.acc & TAPS), comp_q.acc[W-1:1]};
        if (clear_en) begin
            comp_d.acc = '0;
        end else if (step_en) begin
            comp_d.acc = shifted ^ din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q.acc <= '0;
        end else begin
            comp_q <= comp_d;
        end
    end

    assign sig = comp_q.acc;

endmodule

// File: rtl/bist_run_ctrl.sv
module bist_run_ctrl
    import bist_pkg::*;
#(
    parameter int unsigned W  = 4,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          seed_load,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  golden,
    input  logic [W-1:0]  sig,
    output logic          load_en,
    output logic          clear_en,
    output logic          step_en,
    output logic          busy,
    output logic          done,
    output logic          pass
);

    typedef struct packed {
        bist_phase_e  phase;
        logic [CW-1:0] remain;
        logic [W-1:0]  gold;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  running;
    logic  accept_start;

    always_comb begin
        running      = (ctrl_q.phase == PH_RUN);
        accept_start = start && !running;
        ctrl_d       = ctrl_q;

        if (accept_start) begin
            ctrl_d.gold   = golden;
            ctrl_d.remain = count;
            ctrl_d.phase  = (count == '0) ? PH_DONE : PH_RUN;
        end else if (running) begin
            ctrl_d.remain = ctrl_q.remain - CW'(1);
            if (ctrl_q.remain == CW'(1)) begin
                ctrl_d.phase = PH_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.phase  <= PH_IDLE;
            ctrl_q.remain <= '0;
            ctrl_q.gold   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_en  = seed_load && !running;
    assign clear_en = accept_start;
    assign step_en  = running;
    assign busy     = running;
    assign done     = (ctrl_q.phase == PH_DONE);
    assign pass     = done && (sig == ctrl_q.gold);

endmodule

// File: rtl/bist_engine.sv
module bist_engine #(
    parameter int unsigned W         = 4,
    parameter int unsigned CW        = 8,
    parameter logic [W-1:0] TAPS     = 4'b1001,
    parameter logic [W-1:0] RST_SEED = 4'b1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_load,
    input  logic [W-1:0]  seed_in,
    input  logic          start,
    input  logic [CW-1:0] cycle_count,
    input  logic [W-1:0]  golden,
    input  logic [W-1:0]  response,
    output logic [W-1:0]  pattern,
    output logic [W-1:0]  signature,
    output logic          busy,
    output logic          done,
    output logic          pass
);

    logic load_en;
    logic clear_en;
    logic step_en;

    bist_run_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seed_load (seed_load),
        .count     (cycle_count),
        .golden    (golden),
        .sig       (signature),
        .load_en   (load_en),
        .clear_en  (clear_en),
        .step_en   (step_en),
        .busy      (busy),
        .done      (done),
        .pass      (pass)
    );

    bist_pattern_gen #(.W(W), .TAPS(TAPS), .RST_SEED(RST_SEED)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (seed_in),
        .step_en  (step_en),
        .state    (pattern)
    );

    bist_sig_comp #(.W(W), .TAPS(TAPS)) u_comp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_en (clear_en),
        .step_en  (step_en),
        .din      (response),
        .sig      (signature)
    );

endmodule

// File: rtl/bist_engine_chk.sv
module bist_engine_chk #(
    parameter int unsigned W     = 4,
    parameter int unsigned CW    = 8,
    parameter logic [W-1:0] TAPS = 4'b1001
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seed_load,
    input logic          start,
    input logic [CW-1:0] cycle_count,
    input logic [W-1:0]  response,
    input logic [W-1:0]  pattern,
    input logic [W-1:0]  signature,
    input logic          busy,
    input logic          done,
    input logic          pass
);

    assert_pattern_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pattern != '0);

    assert_gen_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> pattern == {^($past(pattern) & TAPS), $past(pattern[W-1:1])});

    assert_gen_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !seed_load) |=> $stable(pattern));

    assert_sig_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> signature == ({^($past(signature) & TAPS), $past(signature[W-1:1])}
                               ^ $past(response)));

    assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> signature == '0);

    assert_start_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cycle_count != '0) |=> busy);

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(pass) && $stable(signature));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cycle_count != '0) |=> (busy || done));

endmodule

bind bist_engine bist_engine_chk #(.W(W), .CW(CW), .TAPS(TAPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_load   (seed_load),
    .start       (start),
    .cycle_count (cycle_count),
    .response    (response),
    .pattern     (pattern),
    .signature   (signature),
    .busy        (busy),
    .done        (done),
    .pass        (pass)
);

// File: tb/sim_bist_engine.sv
module sim_bist_engine;

    localparam int W  = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          seed_load;
    logic [W-1:0]  seed_in;
    logic          start;
    logic [CW-1:0] cycle_count;
    logic [W-1:0]  golden;
    logic [W-1:0]  response;
    logic [W-1:0]  pattern;
    logic [W-1:0]  signature;
    logic          busy;
    logic          done;
    logic          pass;

    logic          fault_en;
    logic [W-1:0]  fault_pat;
    logic [15:0]   seen;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #10 clk = ~clk;

    bist_engine u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
        .start(start), .cycle_count(cycle_count), .golden(golden),
        .response(response), .pattern(pattern), .signature(signature),
        .busy(busy), .done(done), .pass(pass)
    );

    function automatic logic [3:0] gen_next(input logic [3:0] s);
        return {s[3] ^ s[0], s[3:1]};
    endfunction

    function automatic logic [3:0] comp_next(input logic [3:0] s, input logic [3:0] p);
        return {s[3] ^ s[0], s[3:1]} ^ p;
    endfunction

    function automatic logic [3:0] cut(input logic [3:0] p, input logic flt);
        logic [3:0] r;
        r = {p[3] ^ p[1], p[2] & p[0], p[1] | p[3], ~p[0]};
        if (flt) r = r ^ 4'b0100;
        return r;
    endfunction

    always_comb response = cut(pattern, fault_en && (pattern == fault_pat));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [3:0] sd, input int n, input bit flt,
                           input bit disturb, input bit bad_gold);
        logic [3:0] s, good, sig, m, gold;
        bit exp_pass;
        int bc;
        @(negedge clk);
        seed_load = 1'b1; seed_in = sd;
        @(negedge clk);
        seed_load = 1'b0;
        s = (sd == 4'h0) ? 4'h8 : sd;
        check(pattern == s, "R4 seed load", pattern, s);

        good = 4'h0; sig = 4'h0; m = s;
        for (int i = 0; i < n; i++) begin
            good = comp_next(good, cut(m, 1'b0));
            sig  = comp_next(sig, cut(m, flt && (m == fault_pat)));
            m    = gen_next(m);
        end
        gold     = bad_gold ? (good ^ 4'h1) : good;
        exp_pass = (sig == gold);
        fault_en = flt;

        start = 1'b1; cycle_count = CW'(n); golden = gold;
        @(negedge clk);
        start = 1'b0;
        m = s; bc = 0; seen = 16'h0;
        while (busy && bc < n + 4) begin
            if (bc == 0) check(signature == 4'h0, "R5 cleared at start", signature, 0);
            check(pattern == m, "R2 pattern step", pattern, m);
            seen[m] = 1'b1;
            if (disturb && bc == 2) begin
                seed_load = 1'b1; seed_in = 4'h3; start = 1'b1; cycle_count = 8'd2;
            end else begin
                seed_load = 1'b0; start = 1'b0;
            end
            m = gen_next(m);
            bc++;
            @(negedge clk);
        end
        seed_load = 1'b0; start = 1'b0;
        check(bc == n, disturb ? "R9 run length under disturbance" : "R7 run length", bc, n);
        check(done == 1'b1, "R7 done after run", done, 1);
        check(signature == sig, "R6 final signature", signature, sig);
        check(pass == exp_pass, "R8 pass flag", pass, exp_pass);
        check(pattern == m, disturb ? "R9 pattern unaffected" : "R2 hold after run", pattern, m);
        repeat (3) @(negedge clk);
        check(done && pass == exp_pass && signature == sig, "R8 result held",
              {done, pass, signature}, {1'b1, exp_pass, sig});
        fault_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; seed_load = 1'b0; seed_in = '0; start = 1'b0;
        cycle_count = '0; golden = '0; fault_en = 1'b0; fault_pat = 4'hB;
        repeat (3) @(negedge clk);
        check(pattern == 4'h8 && signature == 4'h0 && !busy && !done && !pass,
              "R1 reset state", {pattern, signature, busy, done, pass}, {4'h8, 4'h0, 3'b000});
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(pattern == 4'h8, "R2 idle hold", pattern, 8);

        // R3: full period from 1000
        run_one(4'h8, 15, 1'b0, 1'b0, 1'b0);
        check(seen == 16'hFFFE, "R3 all non-zero states visited", seen, 16'hFFFE);
        check(pattern == 4'h8, "R3 period returns to seed", pattern, 8);

        // sweep of every seed (R4 zero substitution included) and several lengths
        for (int sd = 0; sd < 16; sd++) begin
            run_one(4'(sd), 1, 1'b0, 1'b0, 1'b0);
            run_one(4'(sd), 4, 1'b0, 1'b0, 1'b0);
            run_one(4'(sd), 15, 1'b0, 1'b0, 1'b0);
            run_one(4'(sd), 33, 1'b0, 1'b0, 1'b0);
        end

        // R8: injected response error must fail; wrong golden must fail
        fault_pat = 4'hB;
        run_one(4'h8, 20, 1'b1, 1'b0, 1'b0);
        fault_pat = 4'h6;
        run_one(4'h3, 40, 1'b1, 1'b0, 1'b0);
        run_one(4'h5, 9, 1'b0, 1'b0, 1'b1);

        // R7: zero-length runs
        run_one(4'h6, 0, 1'b0, 1'b0, 1'b0);
        run_one(4'h6, 0, 1'b0, 1'b0, 1'b1);

        // R9: seed load and start mid-run
        run_one(4'h2, 10, 1'b0, 1'b1, 1'b0);
        run_one(4'h9, 3, 1'b0, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule